// File: doc/BRIEF.md
# Oversampled Byte Serializer

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A byte enters a one-entry holding buffer through a write strobe. As soon as the shift stage is free, the byte moves into it and is sent as a frame:

- a low start bit,
- eight data bits, least significant first,
- an optional parity bit,
- a high stop bit.

Bit timing comes from a shared enable pulse at sixteen times the bit rate. Every bit stays on the line for exactly sixteen of those pulses.

A buffer-ready status output tells the processor when it may write. Ready drops when a byte is accepted. It comes back when that byte starts transmitting, so the next byte can wait in the buffer while the current frame goes out. Frames then follow each other with no idle gap. A two-bit mode input selects no parity, even parity or odd parity. The mode is captured when a byte enters the shift stage. Between frames the line rests high.

Top module: `octet_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and `buf_rdy` is 1 while the buffer is empty.
- R2: A frame is a start bit of 0, then the eight data bits least significant bit first, then a stop bit of 1. Each bit is held for exactly 16 `tick` pulses.
- R3: When the transmitter is idle, a byte accepted at one clock edge moves into the shift stage at the next edge, and `txd` drops to 0 right after that edge, without waiting for a `tick`.
- R4: `par_mode` encoding: 2'b00 means no parity (the parity slot is skipped), 2'b01 means even, 2'b10 means odd, and 2'b11 behaves like 2'b00.
- R5: With even parity, the parity bit makes the count of ones over data and parity even. With odd parity, it makes that count odd. The parity bit sits between the last data bit and the stop bit.
- R6: `buf_rdy` is 0 in the cycle after an accepted write. It returns to 1 in the same cycle that the start bit of that byte appears on `txd`.
- R7: A `wr_stb` while `buf_rdy` is 0 is ignored. The held byte is not replaced, and no extra frame is sent.
- R8: If a byte is waiting when a stop bit completes its 16th pulse, the next start bit begins right after that edge, with no idle cycles between frames.
- R9: `par_mode` is sampled when a byte enters the shift stage. Changes during a frame do not affect that frame.
- R10: `txd` rises only right after a clock edge at which `tick` was 1. It changes without a `tick` only when a start bit begins from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable pulse at sixteen times the bit rate |
| wr_stb | input | 1 | Buffer write strobe |
| wr_byte | input | 8 | Byte to transmit |
| par_mode | input | 2 | Parity mode (00 none, 01 even, 10 odd, 11 none) |
| txd | output | 1 | Serial line, high when idle |
| buf_rdy | output | 1 | Holding buffer can accept a byte |

## Verification
A wrong bit index, shift value or latched parity shows up on `txd` within one bit time: a 0 and a 1 swap inside the frame that is being sent. A bit counter that is off by one stretches or shortens a bit by one `tick`, so the error appears at the very next bit boundary. A holding-buffer flag that is set or cleared at the wrong time shows up on `buf_rdy` in the next cycle, or as an extra, missing or delayed start bit. Comparing both outputs on every clock catches each of these at the first cycle where it differs.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   typedef enum logic [1:0] {
      PM_NONE     = 2'd0,
      PM_EVEN     = 2'd1,
      PM_ODD      = 2'd2,
      PM_NONE_ALT = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } phase_e;

   function automatic logic par_slot_used(input par_mode_e m);
      return (m == PM_EVEN) || (m == PM_ODD);
   endfunction

endpackage

// File: rtl/ser_tx_holdbuf.sv
module ser_tx_holdbuf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stb,
   input  logic [W-1:0] wr_data,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] data
);
   logic accept;

   // a write counts only while the slot is empty
   assign accept = wr_stb & ~full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else begin
         if (take)
            full <= 1'b0;
         else if (accept)
            full <= 1'b1;
         if (accept)
            data <= wr_data;
      end
   end
endmodule

// File: rtl/ser_tx_bitclock.sv
module ser_tx_bitclock #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic bit_end
);
   localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   logic [CW-1:0] cnt;

   assign bit_end = tick && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         cnt <= '0;
      else if (tick)
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/ser_tx_parity.sv
module ser_tx_parity
   import ser_tx_pkg::*;
#(
   parameter int W         = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic [W-1:0] data,
   input  logic [1:0]   mode,
   output logic         use_slot,
   output logic         par_bit
);
   generate
      if (PARITY_EN) begin : g_par
         par_mode_e m;
         assign m        = par_mode_e'(mode);
         assign use_slot = par_slot_used(m);
         // even: bit equals XOR of data; odd: inverted
         assign par_bit  = (^data) ^ (m == PM_ODD);
      end else begin : g_nopar
         logic unused_ok;
         assign unused_ok = ^{data, mode};
         assign use_slot  = 1'b0;
         assign par_bit   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ser_tx_framer.sv
module ser_tx_framer
   import ser_tx_pkg::*;
#(
   parameter int W         = 8,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_end,
   input  logic         buf_full,
   input  logic [W-1:0] buf_data,
   input  logic [1:0]   par_mode,
   output logic         take,
   output logic         line
);
   localparam int IW = (W > 1) ? $clog2(W) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

   phase_e        phase;
   logic [W-1:0]  shreg;
   logic [IW-1:0] idx;
   logic          par_q;
   logic          par_use_q;
   logic          par_use_n;
   logic          par_bit_n;

   ser_tx_parity #(.W(W), .PARITY_EN(PARITY_EN)) u_par (
      .data     (buf_data),
      .mode     (par_mode),
      .use_slot (par_use_n),
      .par_bit  (par_bit_n)
   );

   // load from idle, or right at the end of a stop bit
   assign take = buf_full &&
                 ((phase == PH_IDLE) || ((phase == PH_STOP) && bit_end));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         shreg     <= '0;
         idx       <= '0;
         par_q     <= 1'b0;
         par_use_q <= 1'b0;
      end else if (take) begin
         phase     <= PH_START;
         shreg     <= buf_data;
         idx       <= '0;
         par_q     <= par_bit_n;
         par_use_q <= par_use_n;
      end else if (bit_end) begin
         case (phase)
            PH_START: phase <= PH_DATA;
            PH_DATA: begin
               if (idx == LAST_IDX) begin
                  phase <= par_use_q ? PH_PAR : PH_STOP;
               end else begin
                  idx   <= idx + 1'b1;
                  shreg <= shreg >> 1;
               end
            end
            PH_PAR:  phase <= PH_STOP;
            PH_STOP: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      case (phase)
         PH_START: line = 1'b0;
         PH_DATA:  line = shreg[0];
         PH_PAR:   line = par_q;
         default:  line = 1'b1;
      endcase
   end
endmodule

// File: rtl/octet_serializer.sv
module octet_serializer #(
   parameter int DATA_W    = 8,
   parameter int OVS       = 16,
   parameter bit PARITY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic [1:0]        par_mode,
   output logic              txd,
   output logic              buf_rdy
);
   generate
      if (OVS < 2) begin : g_bad_ovs
         $error("octet_serializer: OVS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("octet_serializer: DATA_W must be at least 1");
      end
   endgenerate

   logic              full;
   logic [DATA_W-1:0] held;
   logic              take;
   logic              bit_end;

   ser_tx_holdbuf #(.W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_data (wr_byte),
      .take    (take),
      .full    (full),
      .data    (held)
   );

   ser_tx_bitclock #(.OVS(OVS)) u_clk (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (take),
      .bit_end (bit_end)
   );

   ser_tx_framer #(.W(DATA_W), .PARITY_EN(PARITY_EN)) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_end  (bit_end),
      .buf_full (full),
      .buf_data (held),
      .par_mode (par_mode),
      .take     (take),
      .line     (txd)
   );

   assign buf_rdy = ~full;
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
   parameter int OVS = 16
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic wr_stb,
   input logic txd,
   input logic buf_rdy
);
   localparam int LIM = 10 * OVS;
   localparam int LW  = $clog2(LIM + 2) + 1;

   logic [LW-1:0] low_ticks;

   always_ff @(posedge clk) begin
      if (!rst_n || txd)
         low_ticks <= '0;
      else if (tick && (low_ticks <= LW'(LIM)))
         low_ticks <= low_ticks + 1'b1;
   end

   // R6
   rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && buf_rdy) |=> !buf_rdy);

   // R6
   rdy_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_rdy) |-> !txd);

   // R10
   line_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txd) |-> $past(tick));

   // R2
   low_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_ticks <= LW'(LIM));
endmodule

bind octet_serializer ser_tx_chk #(.OVS(OVS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .wr_stb  (wr_stb),
   .txd     (txd),
   .buf_rdy (buf_rdy)
);

// File: tb/tb_octet_serializer.sv
module tb_octet_serializer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic [1:0] par_mode = 2'b00;
   logic       txd;
   logic       buf_rdy;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   int    tick_div = 1;
   bit    finished = 1'b0;

   always #2.5 clk = ~clk;

   octet_serializer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_stb(wr_stb),
      .wr_byte(wr_byte), .par_mode(par_mode), .txd(txd), .buf_rdy(buf_rdy)
   );

   // behavioural reference: queue of line levels per frame
   bit       m_full;
   bit [7:0] m_buf;
   bit       m_act;
   bit       m_q[$];
   int       m_cnt;
   bit       m_fold;
   bit       m_acc;
   bit       m_par;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_full = 0; m_buf = 0; m_act = 0; m_cnt = 0; m_q.delete();
      end else begin
         m_fold = m_full;
         m_acc  = wr_stb && !m_full;
         if (m_act && tick) begin
            m_cnt++;
            if (m_cnt == 16) begin
               m_cnt = 0;
               void'(m_q.pop_front());
               if (m_q.size() == 0) m_act = 0;
            end
         end
         if (!m_act && m_fold) begin
            m_q.push_back(1'b0);
            m_par = 0;
            for (int i = 0; i < 8; i++) begin
               m_q.push_back(m_buf[i]);
               m_par = m_par ^ m_buf[i];
            end
            if (par_mode == 2'b01) m_q.push_back(m_par);
            if (par_mode == 2'b10) m_q.push_back(!m_par);
            m_q.push_back(1'b1);
            m_full = 0; m_act = 1; m_cnt = 0;
         end
         if (m_acc) begin
            m_full = 1; m_buf = wr_byte;
         end
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !finished) begin
            check(txd == (m_act ? m_q[0] : 1'b1), "txd",
                  int'(txd), int'(m_act ? m_q[0] : 1'b1));
            check(buf_rdy == !m_full, "buf_rdy", int'(buf_rdy), int'(!m_full));
         end
      end
   end

   // tick source: periodic when tick_div > 0, random otherwise
   initial begin
      int c;
      c = 0;
      forever begin
         @(negedge clk);
         if (tick_div > 0) begin
            tick = (c == 0);
            c = (c + 1 >= tick_div) ? 0 : c + 1;
         end else begin
            tick = $urandom_range(1, 0) == 1;
         end
      end
   end

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_byte = b;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_act || m_full) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_rdy();
      while (!buf_rdy) @(negedge clk);
   endtask

   task automatic send(input logic [1:0] mode, input logic [7:0] b, input string req);
      cur_req  = req;
      par_mode = mode;
      put_byte(b);
      wait_idle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check(txd == 1'b1, "reset txd", int'(txd), 1);
      check(buf_rdy == 1'b1, "reset buf_rdy", int'(buf_rdy), 1);

      tick_div = 1;
      // R2 R3: plain frame, tick every cycle
      send(2'b00, 8'hA5, "R2");
      send(2'b00, 8'h01, "R3");
      cur_req = "R1";
      check(txd == 1'b1, "idle txd", int'(txd), 1);
      // R5 parity values, R4 encodings
      send(2'b01, 8'h07, "R5");
      send(2'b01, 8'h03, "R5");
      send(2'b10, 8'h00, "R5");
      send(2'b10, 8'hFF, "R5");
      send(2'b11, 8'h3C, "R4");

      // R8 back-to-back, R6 ready timing, R7 ignored write
      cur_req  = "R8";
      par_mode = 2'b01;
      put_byte(8'h81);
      wait_rdy();
      put_byte(8'h7E);
      cur_req = "R6";
      check(buf_rdy == 1'b0, "ready after queue", int'(buf_rdy), 0);
      cur_req = "R7";
      put_byte(8'h55);
      check(buf_rdy == 1'b0, "ready after ignored write", int'(buf_rdy), 0);
      cur_req = "R8";
      wait_idle();

      // R9: mode change mid-frame
      cur_req  = "R9";
      par_mode = 2'b01;
      put_byte(8'h01);
      repeat (20) @(negedge clk);
      par_mode = 2'b10;
      wait_idle();

      // R10: sparse and irregular ticks
      cur_req  = "R10";
      tick_div = 3;
      send(2'b10, 8'h96, "R10");
      tick_div = 0;
      send(2'b01, 8'h5A, "R10");
      par_mode = 2'b00;
      put_byte(8'hC3);
      wait_rdy();
      put_byte(8'h2D);
      wait_idle();
      cur_req = "R1";
      check(txd == 1'b1 && buf_rdy == 1'b1, "final idle", int'({txd, buf_rdy}), 3);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule